// File: doc/BRIEF.md
# Two-Bank SDR SDRAM Controller

This block turns single-word read and write requests into command sequences for a 16-bit single-data-rate SDRAM with two banks. After reset it waits out the power-up time and closes every bank. It then issues a programmable number of auto-refresh cycles and loads the mode word, which selects a burst of one word, sequential order and the configured CAS latency. Only after that does it accept traffic.

Each bank has a tracker that records whether a row is open and which row it is. A request that hits the open row goes straight to a column command. A request that misses first precharges that bank alone and then activates the new row. A request may ask for the row to be closed right after the access; the controller then sets the auto-precharge flag on the column command. A free-running timer raises a refresh request once every configured interval. That request wins over new traffic. The controller closes any open row with a precharge of all banks and then issues the refresh.

The request side uses valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle, so only one request is in flight at a time. While `req_ready` is low the requester must hold its request steady. Read data comes back in request order as a one-cycle `rsp_valid` pulse and cannot be back-pressured.

Top module: `sdr_ctrl`

## Requirements
- R1: While `rst_n` is low, `sd_cs_n` is high, `sd_cke` is low, and `req_ready` and `rsp_valid` are low.
- R2: The first command after power-up is a precharge with address bit 10 high. At least INIT_REFS (2 by default) auto-refreshes follow. Then comes a load-mode command whose opcode has bits [2:0]=000 (one-word bursts), bit 3=0 (sequential) and bits [6:4]=CAS_LAT. `req_ready` stays low until that load-mode command has been issued.
- R3: Commands use {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001, LOAD-MODE 0000. The code 0110 is never issued.
- R4: READ/WRITE follows the ACTIVE of its bank by at least T_RCD cycles. ACTIVE or refresh follows a precharge of the bank by at least T_RP cycles. No command follows a refresh within T_RFC cycles. No command follows a load-mode within T_MRD cycles.
- R5: `req_addr` is {bank[19], row[18:8], col[7:0]}. ACTIVE drives the row on `sd_addr[10:0]`. READ/WRITE drive the column on `sd_addr[7:0]`. Both drive the bank on `sd_addr[11]`.
- R6: A request to the row already open in its bank issues no ACTIVE and no PRECHARGE. A request to a different row of an open bank issues one PRECHARGE with `sd_addr[10]`=0 and `sd_addr[11]`=bank, then one ACTIVE.
- R7: `req_close`=1 puts `sd_addr[10]`=1 on the column command, and the next access to that bank starts with ACTIVE and no PRECHARGE. `req_close`=0 puts `sd_addr[10]`=0 there.
- R8: In the WRITE command cycle `sd_dq_oe`=1, `sd_dq_out` carries the write data, and `sd_dqm`=~`req_be` (bit 0 lower byte, bit 1 upper byte, high means masked). A masked byte keeps its old content.
- R9: Each accepted read yields exactly one `rsp_valid` pulse, in request order. `rsp_rdata` is `sd_dq_in` sampled CAS_LAT rising edges after the edge at which the device samples READ.
- R10: Auto-refresh is issued only with both banks closed. Open rows are closed beforehand by a precharge with `sd_addr[10]`=1. After initialisation, successive refreshes lie no more than REF_CYC plus one request's service time apart.
- R11: While a refresh is pending, `req_ready` is low, so refresh cannot be starved by continuous traffic.
- R12: `req_ready` is high only when the controller is idle. In the cycle after an acceptance it is low.
- R13: `sd_dq_oe` is high only in a cycle that carries a WRITE command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 write, 0 read |
| req_close | input | 1 | Close the row after the access |
| req_addr | input | 20 | {bank, row, column} word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address; bit 11 bank, bit 10 precharge mode |
| sd_dqm | output | 2 | Byte masks, active high |
| sd_dq_out | output | 16 | Data toward the SDRAM |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from the SDRAM |

## Verification
The bench builds the controller with CAS_LAT=3 and a power-up wait of 20 cycles. It also shortens REF_CYC to 120 cycles, so refreshes arrive every few requests. This puts the precharge-all-then-refresh path, and its collision with a saturated request stream, within reach of a short run. The latency of 3 exercises the deeper read-capture path. With the default timing of 2/2/7/2 cycles, every spacing rule is checked by the behavioural memory model against real command gaps.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int NUM_BANKS = 2;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111,
    CMD_DESL = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT, ST_IPRE, ST_IREF, ST_IMRS, ST_IDLE, ST_DEC,
    ST_PRE1, ST_ACT, ST_RW, ST_PREA, ST_REF
  } sdr_state_e;
endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int REF_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(REF_CYC + 1);
  logic [TW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      pend <= 1'b0;
    end else begin
      if (tick == TW'(REF_CYC - 1)) tick <= '0;
      else                          tick <= tick + 1'b1;
      if (tick == TW'(REF_CYC - 1)) pend <= 1'b1;
      else if (ack)                 pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track import sdr_pkg::*; #(
  parameter int ROW_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bank,
  input  logic [ROW_W-1:0]     row,
  input  logic                 open_en,
  input  logic                 close_en,
  input  logic                 close_all,
  output logic [NUM_BANKS-1:0] open_vec,
  output logic                 q_open,
  output logic [ROW_W-1:0]     q_row
);
  logic [ROW_W-1:0] row_r [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vec[b] <= 1'b0;
        row_r[b]    <= '0;
      end else if (close_all || (close_en && bank == 1'(b))) begin
        open_vec[b] <= 1'b0;
      end else if (open_en && bank == 1'(b)) begin
        open_vec[b] <= 1'b1;
        row_r[b]    <= row;
      end
    end
  end

  assign q_open = open_vec[bank];
  assign q_row  = row_r[bank];
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issued,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [CAS_LAT-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      stage     <= {stage[CAS_LAT-2:0], issued};
      rsp_valid <= stage[CAS_LAT-1];
      if (stage[CAS_LAT-1]) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl import sdr_pkg::*; #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int DW        = 16,
  parameter int CAS_LAT   = 2,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_PWR     = 20000,
  parameter int REF_CYC   = 1560,
  parameter int INIT_REFS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic                     req_close,
  input  logic [ROW_W+COL_W:0]     req_addr,
  input  logic [DW-1:0]            req_wdata,
  input  logic [DW/8-1:0]          req_be,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     sd_cke,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [ROW_W:0]           sd_addr,
  output logic [DW/8-1:0]          sd_dqm,
  output logic [DW-1:0]            sd_dq_out,
  output logic                     sd_dq_oe,
  input  logic [DW-1:0]            sd_dq_in
);
  localparam int AW     = ROW_W + 1;
  localparam int RA_W   = ROW_W + COL_W + 1;
  localparam int AP_BIT = 10;
  localparam int CNT_W  = $clog2(T_PWR + T_RFC + T_WR + T_RP + T_RCD + T_MRD + CAS_LAT + 4);
  localparam int IR_W   = $clog2(INIT_REFS + 1);
  localparam logic [AW-1:0] MODE_WORD = AW'(CAS_LAT << 4);

  sdr_state_e         st, ret;
  logic [CNT_W-1:0]   cnt, rw_wait;
  logic [IR_W-1:0]    iref;
  sdr_cmd_e           cmd_q;
  logic [AW-1:0]      addr_q;
  logic [DW/8-1:0]    dqm_q;
  logic [DW-1:0]      dout_q;
  logic               oe_q, rd_issue, cke_q;

  logic               q_we, q_close, q_bank;
  logic [ROW_W-1:0]   q_row;
  logic [COL_W-1:0]   q_col;
  logic [DW-1:0]      q_data;
  logic [DW/8-1:0]    q_be;

  logic               ref_pend, ref_ack;
  logic [NUM_BANKS-1:0] open_vec;
  logic               trk_open;
  logic [ROW_W-1:0]   trk_row;

  function automatic logic [AW-1:0] col_word(logic b, logic ap, logic [COL_W-1:0] c);
    logic [AW-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    w[AP_BIT]    = ap;
    w[ROW_W]     = b;
    return w;
  endfunction

  sdr_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pend(ref_pend)
  );

  sdr_bank_track #(.ROW_W(ROW_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .bank(q_bank), .row(q_row),
    .open_en(st == ST_ACT),
    .close_en(st == ST_PRE1 || (st == ST_RW && q_close)),
    .close_all(st == ST_IPRE || st == ST_PREA),
    .open_vec(open_vec), .q_open(trk_open), .q_row(trk_row)
  );

  sdr_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .issued(rd_issue), .dq_in(sd_dq_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign ref_ack   = (st == ST_REF);
  assign req_ready = (st == ST_IDLE) && !ref_pend;

  always_comb begin
    rw_wait = q_we ? CNT_W'(T_WR - 1) : CNT_W'(CAS_LAT);
    if (q_close) rw_wait = rw_wait + CNT_W'(T_RP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_WAIT;
      ret      <= ST_IPRE;
      cnt      <= CNT_W'(T_PWR - 1);
      iref     <= '0;
      cmd_q    <= CMD_DESL;
      addr_q   <= '0;
      dqm_q    <= '0;
      dout_q   <= '0;
      oe_q     <= 1'b0;
      rd_issue <= 1'b0;
      cke_q    <= 1'b0;
      q_we     <= 1'b0;
      q_close  <= 1'b0;
      q_bank   <= 1'b0;
      q_row    <= '0;
      q_col    <= '0;
      q_data   <= '0;
      q_be     <= '0;
    end else begin
      cmd_q    <= CMD_NOP;
      oe_q     <= 1'b0;
      dqm_q    <= '0;
      rd_issue <= 1'b0;
      cke_q    <= 1'b1;
      unique case (st)
        ST_WAIT: begin
          if (cnt == '0) st <= ret;
          else           cnt <= cnt - 1'b1;
        end
        ST_IPRE: begin
          cmd_q  <= CMD_PRE;
          addr_q <= col_word(1'b0, 1'b1, '0);
          cnt <= CNT_W'(T_RP - 1); ret <= ST_IREF; st <= ST_WAIT;
        end
        ST_IREF: begin
          cmd_q <= CMD_REF;
          iref  <= iref + 1'b1;
          cnt <= CNT_W'(T_RFC - 1); st <= ST_WAIT;
          ret <= (iref == IR_W'(INIT_REFS - 1)) ? ST_IMRS : ST_IREF;
        end
        ST_IMRS: begin
          cmd_q  <= CMD_LMR;
          addr_q <= MODE_WORD;
          cnt <= CNT_W'(T_MRD - 1); ret <= ST_IDLE; st <= ST_WAIT;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            st <= (open_vec != '0) ? ST_PREA : ST_REF;
          end else if (req_valid) begin
            q_we    <= req_we;
            q_close <= req_close;
            q_bank  <= req_addr[RA_W-1];
            q_row   <= req_addr[COL_W +: ROW_W];
            q_col   <= req_addr[COL_W-1:0];
            q_data  <= req_wdata;
            q_be    <= req_be;
            st      <= ST_DEC;
          end
        end
        ST_DEC: begin
          if (trk_open && trk_row == q_row) st <= ST_RW;
          else if (trk_open)                st <= ST_PRE1;
          else                              st <= ST_ACT;
        end
        ST_PRE1: begin
          cmd_q  <= CMD_PRE;
          addr_q <= col_word(q_bank, 1'b0, '0);
          cnt <= CNT_W'(T_RP - 1); ret <= ST_ACT; st <= ST_WAIT;
        end
        ST_ACT: begin
          cmd_q  <= CMD_ACT;
          addr_q <= {q_bank, q_row};
          cnt <= CNT_W'(T_RCD - 1); ret <= ST_RW; st <= ST_WAIT;
        end
        ST_RW: begin
          cmd_q  <= q_we ? CMD_WR : CMD_RD;
          addr_q <= col_word(q_bank, q_close, q_col);
          if (q_we) begin
            oe_q   <= 1'b1;
            dout_q <= q_data;
            dqm_q  <= ~q_be;
          end else begin
            rd_issue <= 1'b1;
          end
          cnt <= rw_wait; ret <= ST_IDLE; st <= ST_WAIT;
        end
        ST_PREA: begin
          cmd_q  <= CMD_PRE;
          addr_q <= col_word(1'b0, 1'b1, '0);
          cnt <= CNT_W'(T_RP - 1); ret <= ST_REF; st <= ST_WAIT;
        end
        ST_REF: begin
          cmd_q <= CMD_REF;
          cnt <= CNT_W'(T_RFC - 1); ret <= ST_IDLE; st <= ST_WAIT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sd_cke    = cke_q;
  assign sd_cs_n   = cmd_q[3];
  assign sd_ras_n  = cmd_q[2];
  assign sd_cas_n  = cmd_q[1];
  assign sd_we_n   = cmd_q[0];
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dout_q;
  assign sd_dq_oe  = oe_q;
endmodule

// File: rtl/sdr_ctrl_chk.sv
module sdr_ctrl_chk #(
  parameter int T_RCD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic       sd_dq_oe,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       ref_pend,
  input logic [1:0] open_vec
);
  logic [3:0] cmd;
  logic [7:0] since_act;
  logic       mrs_seen;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      mrs_seen  <= 1'b0;
    end else begin
      if (cmd == 4'b0011)        since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
      if (cmd == 4'b0000) mrs_seen <= 1'b1;
    end
  end

  a_r3_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> (cmd[2:0] != 3'b110));

  a_r13_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == 4'b0100));

  a_r11_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  a_r10_refresh_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001) |-> (open_vec == 2'b00));

  a_r4_trcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> (since_act >= 8'(T_RCD)));

  a_r2_ready_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mrs_seen);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sdr_ctrl sdr_ctrl_chk #(.T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .ref_pend(ref_pend),
  .open_vec(open_vec)
);

// File: tb/sim_sdr_ctrl.sv
module sim_sdr_ctrl;
  localparam int CL = 3, TRCD = 2, TRP = 2, TRFC = 7, TMRD = 2, TWR = 2;
  localparam int PWR = 20, REFC = 120, SLACK = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_close = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] sd_dq_in = 16'hDEAD;
  logic req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rsp_rdata, sd_dq_out;
  logic [11:0] sd_addr;
  logic [1:0]  sd_dqm;

  always #5 clk = ~clk;

  sdr_ctrl #(.CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
             .T_WR(TWR), .T_PWR(PWR), .REF_CYC(REFC), .INIT_REFS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_close(req_close), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(int key);
    return 16'(key) ^ 16'h5A5A;
  endfunction

  // ---------------- behavioural SDRAM + protocol reference ----------------
  typedef struct { int due; logic [15:0] d; } rd_t;
  logic [15:0] dev_mem [int];
  logic [15:0] shadow  [int];
  rd_t         rdq [$];
  logic [15:0] expq [$];

  int cyc = 0;
  bit open_b [2];
  int row_b [2], act_c [2], free_c [2], wrdone_c [2];
  int ref_free = 0, mrs_free = 0, last_ref = 0;
  bit mrs_seen = 0, first_seen = 0, last_a10 = 0;
  int n_iref = 0, n_act = 0, n_pre1 = 0, n_prea = 0, n_ref = 0, last_pre1_bank = -1;

  always @(negedge clk) begin
    logic [3:0] cmd;
    int b, key;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = int'(sd_addr[11]);
    if (!rst_n) begin
      chk(sd_cs_n && !sd_cke && !req_ready && !rsp_valid, "R1", "reset outputs",
          {28'd0, sd_cs_n, sd_cke, req_ready, rsp_valid}, 32'h8);
    end else begin
      if (!sd_cs_n) chk(cmd[2:0] != 3'b110, "R3", "illegal command code", 32'(cmd), 32'h7);
      if (!sd_cs_n && cmd != 4'b0111 && !first_seen) begin
        first_seen = 1;
        chk(cmd == 4'b0010 && sd_addr[10], "R2", "first command not precharge-all", 32'(cmd), 32'h2);
      end
      if (sd_dq_oe) chk(cmd == 4'b0100, "R13", "data enable outside write", 32'(cmd), 32'h4);
      if (req_ready) chk(mrs_seen, "R2", "ready before mode load", 32'(req_ready), 32'h0);
      case (cmd)
        4'b0011: begin
          chk(mrs_seen && !open_b[b], "R6", "activate on open bank or before init", 32'(open_b[b]), 32'h0);
          chk(cyc >= free_c[b] && cyc >= ref_free && cyc >= mrs_free, "R4", "activate too early", 32'(cyc), 32'(free_c[b]));
          open_b[b] = 1; row_b[b] = int'(sd_addr[10:0]); act_c[b] = cyc; n_act++;
        end
        4'b0101, 4'b0100: begin
          chk(open_b[b], "R6", "column command to closed bank", 32'(b), 32'h0);
          chk(cyc - act_c[b] >= TRCD, "R4", "column command before tRCD", 32'(cyc - act_c[b]), 32'(TRCD));
          key = (b << 19) | (row_b[b] << 8) | int'(sd_addr[7:0]);
          last_a10 = sd_addr[10];
          if (cmd == 4'b0100) begin
            logic [15:0] w;
            chk(sd_dq_oe, "R8", "write without data enable", 32'(sd_dq_oe), 32'h1);
            w = dev_mem.exists(key) ? dev_mem[key] : dflt(key);
            if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
            if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
            dev_mem[key] = w;
            wrdone_c[b] = cyc + TWR;
          end else begin
            rdq.push_back('{due: cyc + CL, d: dev_mem.exists(key) ? dev_mem[key] : dflt(key)});
          end
          if (sd_addr[10]) begin
            open_b[b] = 0;
            free_c[b] = cyc + ((cmd == 4'b0100) ? TWR : 1) + TRP;
          end
        end
        4'b0010: begin
          for (int k = 0; k < 2; k++) begin
            if (sd_addr[10] || k == b) begin
              if (open_b[k]) chk(cyc >= wrdone_c[k], "R4", "precharge before write recovery", 32'(cyc), 32'(wrdone_c[k]));
              open_b[k] = 0; free_c[k] = cyc + TRP;
            end
          end
          if (sd_addr[10]) n_prea++;
          else begin n_pre1++; last_pre1_bank = b; end
        end
        4'b0001: begin
          chk(!open_b[0] && !open_b[1], "R10", "refresh with open bank", {30'd0, open_b[1], open_b[0]}, 32'h0);
          chk(cyc >= free_c[0] && cyc >= free_c[1] && cyc >= ref_free && cyc >= mrs_free, "R4", "refresh too early", 32'(cyc), 32'(ref_free));
          // R10 interval bound; under held request traffic this also shows R11
          if (mrs_seen) chk(cyc - last_ref <= REFC + SLACK, "R11", "refresh interval", 32'(cyc - last_ref), 32'(REFC + SLACK));
          else n_iref++;
          last_ref = cyc; ref_free = cyc + TRFC; n_ref++;
        end
        4'b0000: begin
          chk(n_iref >= 2, "R2", "too few refreshes before mode load", 32'(n_iref), 32'h2);
          chk(sd_addr[6:4] == 3'(CL) && sd_addr[3:0] == 4'h0, "R2", "mode opcode", 32'(sd_addr), 32'(CL << 4));
          chk(!open_b[0] && !open_b[1] && cyc >= free_c[0] && cyc >= ref_free, "R4", "mode load timing", 32'(cyc), 32'(ref_free));
          mrs_seen = 1; mrs_free = cyc + TMRD;
        end
        default: ;
      endcase
      if (rsp_valid) begin
        chk(expq.size() > 0, "R9", "unexpected read response", 32'(rsp_rdata), 32'h0);
        if (expq.size() > 0) begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(rsp_rdata == e, "R9", "R5 read data", 32'(rsp_rdata), 32'(e));
        end
      end
      if (rdq.size() > 0 && rdq[0].due == cyc) sd_dq_in = rdq.pop_front().d;
      else sd_dq_in = 16'hDEAD;
      cyc++;
    end
  end

  // ---------------- request driver ----------------
  task automatic send(bit we, bit bank, int row, int col, logic [15:0] d, logic [1:0] be, bit cls);
    int key;
    req_valid = 1; req_we = we; req_close = cls;
    req_addr = {bank, 11'(row), 8'(col)}; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    key = (int'(bank) << 19) | (row << 8) | col;
    if (we) begin
      logic [15:0] w;
      w = shadow.exists(key) ? shadow[key] : dflt(key);
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[key] = w;
    end else begin
      expq.push_back(shadow.exists(key) ? shadow[key] : dflt(key));
    end
    @(negedge clk);
    chk(!req_ready, "R12", "ready right after acceptance", 32'(req_ready), 32'h0);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_ref();
    int k;
    k = n_ref;
    while (n_ref == k) @(negedge clk);
    idle(12);
  endtask

  initial begin
    int a, p;
    repeat (5) @(negedge clk);
    rst_n = 1;
    while (!req_ready) @(negedge clk);

    // R6 row hit
    sync_ref();
    send(1, 0, 5, 3, 16'h1111, 2'b11, 0);
    send(0, 0, 5, 3, 16'h0, 2'b11, 0);
    a = n_act; p = n_pre1;
    send(0, 0, 5, 9, 16'h0, 2'b11, 0);
    idle(10);
    chk(n_act == a, "R6", "activate on row hit", 32'(n_act), 32'(a));
    chk(n_pre1 == p, "R6", "precharge on row hit", 32'(n_pre1), 32'(p));

    // R6 row miss
    a = n_act; p = n_pre1;
    send(0, 0, 7, 3, 16'h0, 2'b11, 0);
    idle(10);
    chk(n_act == a + 1, "R6", "activates on row miss", 32'(n_act), 32'(a + 1));
    chk(n_pre1 == p + 1 && last_pre1_bank == 0, "R6", "single-bank precharge on miss", 32'(n_pre1), 32'(p + 1));

    // R7 auto-precharge per request
    sync_ref();
    send(1, 1, 9, 1, 16'hBEEF, 2'b11, 1);
    idle(8);
    chk(last_a10 == 1, "R7", "column command close flag", 32'(last_a10), 32'h1);
    a = n_act; p = n_pre1;
    send(0, 1, 9, 1, 16'h0, 2'b11, 0);
    idle(10);
    chk(n_act == a + 1 && n_pre1 == p, "R7", "reopen after auto close", 32'(n_act - a), 32'h1);
    chk(last_a10 == 0, "R7", "column command keep flag", 32'(last_a10), 32'h0);

    // R8 byte masking
    sync_ref();
    send(1, 0, 5, 3, 16'h1234, 2'b11, 0);
    send(1, 0, 5, 3, 16'hABCD, 2'b01, 0);
    send(0, 0, 5, 3, 16'h0, 2'b11, 0);
    send(1, 0, 5, 3, 16'hFFFF, 2'b00, 0);
    send(0, 0, 5, 3, 16'h0, 2'b11, 0);
    send(1, 0, 5, 4, 16'h7788, 2'b10, 0);
    send(0, 0, 5, 4, 16'h0, 2'b11, 0);
    idle(10);

    // saturated random stream, valid held across refreshes (R11)
    for (int i = 0; i < 300; i++) begin
      send(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(1, 3),
           $urandom_range(0, 3), 16'($urandom), 2'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0));
    end
    idle(30);

    chk(expq.size() == 0, "R9", "responses outstanding", 32'(expq.size()), 32'h0);
    chk(rdq.size() == 0, "R9", "device reads outstanding", 32'(rdq.size()), 32'h0);
    chk(n_ref > 10, "R10", "refresh count", 32'(n_ref), 32'd11);
    chk(n_prea > 1, "R10", "precharge-all before refresh", 32'(n_prea), 32'd2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule